// File: doc/BRIEF.md
# Read-Sequence Triggered SRAM Write Controller

This block sits on a ROM socket that has been filled with SRAM. The processor can only issue read cycles to that socket. The block watches the address bus and a ROM-cycle strobe for an exact chain of reads to magic addresses. Each chain begins with a read of 0xFFFD, followed directly by a read of 0xFFFC. The third read then chooses the command.

A third read that falls in page 0xFDxx stores its low address byte in a latch. On the fourth ROM cycle, which may target any address, the block drives that byte onto the data bus and pulses the active-low SRAM write strobe. The processor supplies the address, so the byte lands at that location. A third read that falls in page 0xFCxx instead loads a two-bit bank code. Code 0 routes ROM reads to the boot EPROM, and codes 1 to 3 route them to an SRAM bank.

The ROM-cycle strobe is asynchronous and passes through a synchroniser. The machine advances once per rising edge of the synchronised strobe. Any ROM cycle that does not match the next expected step sends the machine back to the start. Because a normal 16-bit load reads 0xFFFC before 0xFFFD, code running from the ROM cannot trigger a command by accident.

Top module: `rsw_ctrl`

## Requirements
- R1: After reset, bank_sel is 0 (boot EPROM), bus_drive_en is 0, sram_we_n is 1, and the machine waits for step one.
- R2: A command is accepted only after a ROM read of 0xFFFD is followed directly by a ROM read of 0xFFFC.
- R3: Reading 0xFFFC before 0xFFFD never starts a command, so a following page-0xFD or page-0xFC read has no effect.
- R4: After the two key reads, a ROM read in page 0xFDxx captures address bits 7:0 into the byte latch.
- R5: On the next ROM cycle (any address), bus_drive_en is 1 and data_out carries the latched byte. sram_we_n is 0 only while the synchronised strobe of that cycle is high. Both return to inactive once the cycle ends.
- R6: mem_oe_n is 0 during a ROM cycle, except during a write cycle, when it is held at 1 so that the latch alone drives the bus.
- R7: After the two key reads, a ROM read in page 0xFCxx loads address bits 1:0 into bank_sel (0 selects the boot EPROM, 1 to 3 select SRAM banks). No write follows.
- R8: A ROM cycle that does not match the expected step returns the machine to step one. If that cycle is itself a read of 0xFFFD, it counts as a new step one.
- R9: Address changes while rom_cyc is low do not advance or break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| rom_cyc | input | 1 | Asynchronous ROM-cycle strobe, high during a ROM read |
| bus_drive_en | output | 1 | Enables the latch onto the data bus |
| data_out | output | 8 | Latched byte |
| sram_we_n | output | 1 | Active-low SRAM write strobe |
| mem_oe_n | output | 1 | Active-low ROM/SRAM output enable |
| bank_sel | output | 2 | 0 = boot EPROM, 1..3 = SRAM bank |

## Verification
A wrong sequence state shows up at the ports in only two ways. One is a write pulse, a bus drive or a bank change that appears one ROM cycle after a chain that should not have counted. The other is such an effect missing after a chain that should have counted. The bench therefore inspects every ROM cycle in the middle of its strobe and bank_sel after every cycle. A mis-stepped state is then reported within the same or the following ROM cycle. A corrupted latch shows on data_out during the fourth cycle of the write that used it.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_GOT_HI,
    SEQ_GOT_LO,
    SEQ_ARMED,
    SEQ_WRITE
  } seq_state_e;
endpackage

// File: rtl/rsw_strobe_sync.sv
module rsw_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic cyc_active,
  output logic cyc_start
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], strobe_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign cyc_active = sh_q[STAGES-1];
  assign cyc_start  = sh_q[STAGES-1] & ~sh_q[STAGES];

  // a start pulse never lasts two cycles
  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);
endmodule

// File: rtl/rsw_seq_fsm.sv
module rsw_seq_fsm
  import rsw_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [15:0] KEY_HI    = 16'hFFFD,
  parameter logic [15:0] KEY_LO    = 16'hFFFC,
  parameter logic [7:0]  WR_PAGE   = 8'hFD,
  parameter logic [7:0]  BANK_PAGE = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          cyc_active,
  input  logic [AW-1:0] addr,
  output logic          capture_o,
  output logic          bank_load_o,
  output logic          drive_o,
  output logic          we_n_o
);
  localparam int PW = AW - 8;

  seq_state_e state_q, state_d;
  logic hit_hi, hit_lo, in_wr_pg, in_bk_pg;

  assign hit_hi   = (addr == KEY_HI[AW-1:0]);
  assign hit_lo   = (addr == KEY_LO[AW-1:0]);
  assign in_wr_pg = (addr[AW-1:8] == WR_PAGE[PW-1:0]);
  assign in_bk_pg = (addr[AW-1:8] == BANK_PAGE[PW-1:0]);

  always_comb begin
    state_d     = state_q;
    capture_o   = 1'b0;
    bank_load_o = 1'b0;
    if (cyc_start) begin
      unique case (state_q)
        SEQ_IDLE:   state_d = hit_hi ? SEQ_GOT_HI : SEQ_IDLE;
        SEQ_GOT_HI: state_d = hit_lo ? SEQ_GOT_LO : (hit_hi ? SEQ_GOT_HI : SEQ_IDLE);
        SEQ_GOT_LO: begin
          if (in_wr_pg) begin
            capture_o = 1'b1;
            state_d   = SEQ_ARMED;
          end else if (in_bk_pg) begin
            bank_load_o = 1'b1;
            state_d     = SEQ_IDLE;
          end else begin
            state_d = hit_hi ? SEQ_GOT_HI : SEQ_IDLE;
          end
        end
        SEQ_ARMED:  state_d = SEQ_WRITE;
        default:    state_d = SEQ_IDLE;
      endcase
    end else if (state_q == SEQ_WRITE && !cyc_active) begin
      state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign drive_o = (state_q == SEQ_WRITE);
  assign we_n_o  = !((state_q == SEQ_WRITE) && cyc_active);

  assert_write_after_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WRITE && $past(state_q) != SEQ_WRITE) |-> $past(state_q) == SEQ_ARMED);
  assert_write_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WRITE && !cyc_active) |=> state_q == SEQ_IDLE);
  assert_lo_after_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_GOT_LO && $past(state_q) != SEQ_GOT_LO) |-> $past(state_q) == SEQ_GOT_HI);
  assert_step_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cyc_start) && $past(state_q) != SEQ_WRITE) |-> $stable(state_q));
endmodule

// File: rtl/rsw_latch_bank.sv
module rsw_latch_bank #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          bank_load,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] latch_o,
  output logic [BW-1:0] bank_o
);
  logic [DW-1:0] latch_q;
  logic [BW-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (capture) latch_q <= addr[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bank_q <= '0;
    else if (bank_load) bank_q <= addr[BW-1:0];
  end

  assign latch_o = latch_q;
  assign bank_o  = bank_q;

  assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bank_load) |-> $stable(bank_q));
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(latch_q));
endmodule

// File: rtl/rsw_ctrl.sv
module rsw_ctrl #(
  parameter int          AW          = 16,
  parameter int          DW          = 8,
  parameter int          BW          = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] KEY_HI      = 16'hFFFD,
  parameter logic [15:0] KEY_LO      = 16'hFFFC,
  parameter logic [7:0]  WR_PAGE     = 8'hFD,
  parameter logic [7:0]  BANK_PAGE   = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rom_cyc,
  output logic          bus_drive_en,
  output logic [DW-1:0] data_out,
  output logic          sram_we_n,
  output logic          mem_oe_n,
  output logic [BW-1:0] bank_sel
);
  logic [1:0] rst_sh_q;
  logic       rst_n_s;
  logic       cyc_active, cyc_start, capture, bank_load, drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n_s = rst_sh_q[1];

  rsw_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .strobe_async(rom_cyc),
    .cyc_active(cyc_active), .cyc_start(cyc_start)
  );

  rsw_seq_fsm #(
    .AW(AW), .KEY_HI(KEY_HI), .KEY_LO(KEY_LO),
    .WR_PAGE(WR_PAGE), .BANK_PAGE(BANK_PAGE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .cyc_start(cyc_start), .cyc_active(cyc_active),
    .addr(addr), .capture_o(capture), .bank_load_o(bank_load),
    .drive_o(drive), .we_n_o(sram_we_n)
  );

  rsw_latch_bank #(.AW(AW), .DW(DW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .capture(capture), .bank_load(bank_load),
    .addr(addr), .latch_o(data_out), .bank_o(bank_sel)
  );

  assign bus_drive_en = drive;
  assign mem_oe_n     = !(cyc_active && !drive);

  assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sram_we_n |-> mem_oe_n);
  assert_we_inside_drive_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sram_we_n |-> bus_drive_en);
endmodule

// File: tb/rsw_ctrl_test.sv
module rsw_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rom_cyc = 1'b0;
  logic        bus_drive_en, sram_we_n, mem_oe_n;
  logic [7:0]  data_out;
  logic [1:0]  bank_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model: 0 idle, 1 got FFFD, 2 got FFFC, 3 armed
  int         m_st = 0;
  logic [7:0] m_lat = 8'h00;
  logic [1:0] m_bank = 2'd0;

  always #4ns clk = ~clk;

  rsw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rom_cyc(rom_cyc),
    .bus_drive_en(bus_drive_en), .data_out(data_out), .sram_we_n(sram_we_n),
    .mem_oe_n(mem_oe_n), .bank_sel(bank_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_next(input int st, input logic [15:0] a);
    case (st)
      0: return (a == 16'hFFFD) ? 1 : 0;
      1: return (a == 16'hFFFC) ? 2 : ((a == 16'hFFFD) ? 1 : 0);
      2: if (a[15:8] == 8'hFD) return 3;
         else if (a[15:8] == 8'hFC) return 0;
         else return (a == 16'hFFFD) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic rom_read(input logic [15:0] a);
    bit wr;
    wr = (m_st == 3);
    @(negedge clk);
    addr = a;
    rom_cyc = 1'b1;
    repeat (4) @(negedge clk);
    // R5 / R6 mid-cycle checks
    chk(bus_drive_en == wr, "R5 drive", bus_drive_en, wr);
    chk(sram_we_n == !wr, "R5 we_n", sram_we_n, !wr);
    chk(mem_oe_n == wr, "R6 oe_n", mem_oe_n, wr);
    if (wr) chk(data_out == m_lat, "R4 latched byte", data_out, m_lat);
    if (m_st == 2 && a[15:8] == 8'hFD) m_lat = a[7:0];
    if (m_st == 2 && a[15:8] == 8'hFC) m_bank = a[1:0];
    m_st = model_next(m_st, a);
    rom_cyc = 1'b0;
    // R9: address wanders while no ROM cycle is active
    addr = 16'($urandom());
    @(negedge clk);
    addr = ($urandom() % 2) ? 16'hFFFD : 16'hFFFC;
    repeat (2) @(negedge clk);
    chk(bank_sel == m_bank, "R7 bank_sel", bank_sel, m_bank);
    chk(bus_drive_en == 0 && sram_we_n == 1, "R5 release", {bus_drive_en, sram_we_n}, 1);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom() % 6)
      0, 1: return 16'hFFFD;
      2:    return 16'hFFFC;
      3:    return {8'hFD, 8'($urandom())};
      4:    return {8'hFC, 8'($urandom())};
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1999));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(bank_sel == 0, "R1 bank", bank_sel, 0);
    chk(bus_drive_en == 0, "R1 drive", bus_drive_en, 0);
    chk(sram_we_n == 1, "R1 we_n", sram_we_n, 1);
    chk(mem_oe_n == 1, "R1 oe_n", mem_oe_n, 1);

    // R2 R4 R5: plain write of 0x5A to 0x1234
    rom_read(16'hFFFD); rom_read(16'hFFFC); rom_read(16'hFD5A); rom_read(16'h1234);
    // R7: bank switches through every code
    for (int b = 3; b >= 0; b--) begin
      rom_read(16'hFFFD); rom_read(16'hFFFC); rom_read({8'hFC, 6'h2A, 2'(b)});
    end
    rom_read(16'hFFFD); rom_read(16'hFFFC); rom_read(16'hFC02);
    // R3: reversed key order does nothing
    rom_read(16'hFFFC); rom_read(16'hFFFD); rom_read(16'hFD11); rom_read(16'h2000);
    rom_read(16'hFFFC); rom_read(16'hFFFD); rom_read(16'hFC01); rom_read(16'h2000);
    // R8: interruption, then FFFD as fresh start
    rom_read(16'hFFFD); rom_read(16'h0100); rom_read(16'hFFFC); rom_read(16'hFD22);
    rom_read(16'h3000);
    rom_read(16'hFFFD); rom_read(16'hFFFD); rom_read(16'hFFFC); rom_read(16'hFDA5);
    rom_read(16'hFFFD);
    rom_read(16'hFFFD); rom_read(16'hFFFC); rom_read(16'hFFFD); rom_read(16'hFFFC);
    rom_read(16'hFD00); rom_read(16'hFFFC);
    // random mix
    for (int i = 0; i < 2500; i++) rom_read(pick_addr());

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule